// File: doc/BRIEF.md
# Dual-Target Serial Configuration Loader

This block is the three-wire programming front end for the divider settings of a frequency synthesizer. An external host drives a serial clock, a serial data line and an active-low write strobe. While the strobe is low, each rising edge of the serial clock shifts one data bit into a shift register, most significant bit first. A target-select input chooses which register takes the bit. When the input is low, the bit goes into a 20-bit staging word. When the input is high, it goes into an 8-bit auxiliary word.

The staging word is double-buffered. Its value reaches the divider only when it is copied into the 20-bit active word. A rising edge of the write strobe makes that copy, unless the auxiliary target was selected at that moment. A rising edge of a separate hop strobe makes the copy at any time, so a frequency hop can be timed independently of the serial load. The auxiliary word is visible at its output as soon as each bit lands.

All three strobes and the two level inputs are brought into the system clock domain through a two-stage synchronizer. Edges are detected on the synchronized copies. A small state machine with the states IDLE, SHIFT and COMMIT sequences the load:
- IDLE to SHIFT when the synchronized strobe is low.
- SHIFT to COMMIT on a strobe rising edge. On this transition the target select is latched.
- COMMIT back to IDLE after one cycle. In COMMIT the copy to the active word takes place when the latched select is low.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, the active word, the staging word and the auxiliary word are all zero.
- R2: With target select low and the strobe low, each serial-clock rising edge shifts the data bit into bit 0 of the staging word, and the older bits move one place toward bit 19. The first bit sent therefore ends up as the most significant bit.
- R3: With target select high and the strobe low, each serial-clock rising edge shifts the data bit into bit 0 of the auxiliary word. The auxiliary output shows the new value within 4 system clocks of that edge.
- R4: Serial-clock edges while the strobe is high change neither the staging word nor the auxiliary word.
- R5: A strobe rising edge with target select low copies the staging word into the active word within 4 system clocks.
- R6: A hop rising edge copies the staging word into the active word, whatever the state of the strobe and of the target select.
- R7: The active word holds its value while bits are shifted in and changes only on a transfer.
- R8: A strobe rising edge while target select is high leaves the active word unchanged.
- R9: When more bits are shifted in than a register holds, only the last 20 (staging word) or the last 8 (auxiliary word) are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low write strobe; its rising edge commits the staging word |
| hop | input | 1 | Hop strobe; its rising edge commits the staging word |
| aux_sel | input | 1 | Target select: 0 = staging word, 1 = auxiliary word |
| active_word | output | 20 | Active (secondary) divider word |
| aux_word | output | 8 | Auxiliary register contents |

## Verification
A corrupted staging word stays hidden until the next transfer. At that point it appears whole on the active word, at most four system clocks after the strobe or hop edge. So every load is followed by a comparison of the active word against the arithmetically expected value. A wrong shift direction or a stuck bit in the auxiliary register shows on its output after the very next serial-clock edge, which is why every auxiliary bit is checked as it lands. A state machine that commits at the wrong moment shows as an active word that moves during shifting, or that moves after a strobe edge with the auxiliary target selected.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    localparam int PRIM_W = 20;
    localparam int AUX_W  = 8;
    localparam int SYNC_STAGES = 2;

    // positions of the inputs inside the synchronizer vector
    localparam int IN_SCLK = 0;
    localparam int IN_LOAD = 1;
    localparam int IN_HOP  = 2;
    localparam int IN_DATA = 3;
    localparam int IN_SEL  = 4;
    localparam int IN_W    = 5;

    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_SHIFT  = 2'd1,
        LD_COMMIT = 2'd2
    } ld_state_t;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
    parameter int W = 5,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] pipe_q [STAGES];
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_VAL;
                else        pipe_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_VAL;
                else        pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= pipe_q[STAGES-1];
    end

    assign level = pipe_q[STAGES-1];
    assign rise  = pipe_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[WIDTH-2:0], bit_in};
    end
endmodule

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
    import cfg_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_lvl,
    input  logic      load_rise,
    input  logic      sclk_rise,
    input  logic      hop_rise,
    input  logic      sel_lvl,
    output logic      prim_shift,
    output logic      aux_shift,
    output logic      xfer,
    output logic      sel_latched,
    output ld_state_t state_o
);
    ld_state_t state_q, state_d;
    logic      sel_q, sel_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            LD_IDLE: begin
                if (!load_lvl) state_d = LD_SHIFT;
            end
            LD_SHIFT: begin
                if (load_rise) begin
                    state_d = LD_COMMIT;
                    sel_d   = sel_lvl;
                end
            end
            LD_COMMIT: begin
                state_d = load_lvl ? LD_IDLE : LD_SHIFT;
            end
            default: state_d = LD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        prim_shift = 1'b0;
        aux_shift  = 1'b0;
        xfer       = hop_rise;
        unique case (state_q)
            LD_IDLE: ;
            LD_SHIFT: begin
                prim_shift = sclk_rise && !sel_lvl;
                aux_shift  = sclk_rise &&  sel_lvl;
            end
            LD_COMMIT: begin
                if (!sel_q) xfer = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o     = state_q;
    assign sel_latched = sel_q;
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              load_n,
    input  logic              hop,
    input  logic              aux_sel,
    output logic [PRIM_W-1:0] active_word,
    output logic [AUX_W-1:0]  aux_word
);
    localparam logic [IN_W-1:0] SYNC_RST = IN_W'(1) << IN_LOAD;

    logic [IN_W-1:0]   raw_in, lvl, rise;
    logic              prim_shift, aux_shift, xfer, sel_latched;
    logic              hop_rise;
    ld_state_t         state_q;
    logic [PRIM_W-1:0] prim_q;
    logic [PRIM_W-1:0] active_q;

    always_comb begin
        raw_in          = '0;
        raw_in[IN_SCLK] = ser_clk;
        raw_in[IN_LOAD] = load_n;
        raw_in[IN_HOP]  = hop;
        raw_in[IN_DATA] = ser_data;
        raw_in[IN_SEL]  = aux_sel;
    end

    cfg_sync_edge #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .level (lvl),
        .rise  (rise)
    );

    assign hop_rise = rise[IN_HOP];

    cfg_load_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_lvl    (lvl[IN_LOAD]),
        .load_rise   (rise[IN_LOAD]),
        .sclk_rise   (rise[IN_SCLK]),
        .hop_rise    (hop_rise),
        .sel_lvl     (lvl[IN_SEL]),
        .prim_shift  (prim_shift),
        .aux_shift   (aux_shift),
        .xfer        (xfer),
        .sel_latched (sel_latched),
        .state_o     (state_q)
    );

    cfg_shift_reg #(.WIDTH(PRIM_W)) u_prim (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (prim_shift),
        .bit_in   (lvl[IN_DATA]),
        .q        (prim_q)
    );

    cfg_shift_reg #(.WIDTH(AUX_W)) u_aux (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (aux_shift),
        .bit_in   (lvl[IN_DATA]),
        .q        (aux_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    active_q <= '0;
        else if (xfer) active_q <= prim_q;
    end

    assign active_word = active_q;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk
    import cfg_loader_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PRIM_W-1:0] active_word,
    input logic [AUX_W-1:0]  aux_word,
    input logic [PRIM_W-1:0] prim_q,
    input ld_state_t         state_q,
    input logic              sel_latched,
    input logic              hop_rise
);
    // R2: the staging word only ever moves by one place toward the MSB
    p_prim_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prim_q) |-> prim_q[PRIM_W-1:1] == $past(prim_q[PRIM_W-2:0]));

    // R3: the auxiliary word only ever moves by one place toward the MSB
    p_aux_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(aux_word) |-> aux_word[AUX_W-1:1] == $past(aux_word[AUX_W-2:0]));

    // R4: nothing shifts while the state machine is idle
    p_idle_no_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_IDLE) |=> ($stable(prim_q) && $stable(aux_word)));

    // R5, R7: the active word only ever takes the previous staging value
    p_copy_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_word) |-> active_word == $past(prim_q));

    // R8: a commit with the auxiliary target latched does not touch the active word
    p_aux_commit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_COMMIT && sel_latched && !hop_rise) |=> $stable(active_word));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_word (active_word),
    .aux_word    (aux_word),
    .prim_q      (prim_q),
    .state_q     (state_q),
    .sel_latched (sel_latched),
    .hop_rise    (hop_rise)
);

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        load_n = 1'b1;
    logic        hop = 1'b0;
    logic        aux_sel = 1'b0;
    logic [19:0] active_word;
    logic [7:0]  aux_word;

    int checks = 0;
    int failures = 0;

    // bench models
    logic [19:0] prim_m = '0;
    logic [19:0] act_m  = '0;
    logic [7:0]  aux_m  = '0;

    always #4 clk = ~clk;

    cfg_serial_loader u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .load_n(load_n), .hop(hop), .aux_sel(aux_sel),
        .active_word(active_word), .aux_word(aux_word)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one serial bit; models the staging or auxiliary word and checks it
    task automatic send_bit(input logic b);
        ser_data = b;
        wait_clk(3);
        ser_clk = 1'b1;
        wait_clk(6);
        if (!load_n) begin
            if (aux_sel) aux_m = {aux_m[6:0], b};
            else         prim_m = {prim_m[18:0], b};
        end
        if (aux_sel) chk("R3 aux bit", {24'd0, aux_word}, {24'd0, aux_m});
        else         chk("R7 active held", {12'd0, active_word}, {12'd0, act_m});
        ser_clk = 1'b0;
        wait_clk(3);
    endtask

    task automatic shift_word(input logic [31:0] val, input int n, input logic sel);
        aux_sel = sel;
        wait_clk(4);
        load_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) send_bit(val[i]);
    endtask

    task automatic strobe_up;
        load_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic hop_pulse;
        hop = 1'b1;
        wait_clk(8);
        hop = 1'b0;
        wait_clk(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1: reset state
        chk("R1 active", {12'd0, active_word}, 32'd0);
        chk("R1 aux", {24'd0, aux_word}, 32'd0);
        hop_pulse();
        chk("R1 staging via hop", {12'd0, active_word}, 32'd0);

        // R3, R8: full sweep of the auxiliary register
        for (int v = 0; v < 256; v++) begin
            shift_word(32'(v), 8, 1'b1);
            strobe_up();
            chk("R3 aux word", {24'd0, aux_word}, 32'(v));
            chk("R8 active kept", {12'd0, active_word}, {12'd0, act_m});
        end

        // R2, R5, R7: staging loads committed by the strobe
        for (int k = 0; k < 32; k++) begin
            logic [19:0] w;
            w = 20'((k * 32'h0B3C5 + 32'h5A3) ^ (32'h1 << (k % 20)));
            shift_word({12'd0, w}, 20, 1'b0);
            chk("R7 before commit", {12'd0, active_word}, {12'd0, act_m});
            strobe_up();
            act_m = prim_m;
            chk("R2 R5 active after load", {12'd0, active_word}, {12'd0, w});
        end

        // R4: serial clocks with the strobe high change nothing
        aux_sel = 1'b1;
        wait_clk(4);
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        chk("R4 aux untouched", {24'd0, aux_word}, {24'd0, aux_m});
        aux_sel = 1'b0;
        wait_clk(4);
        for (int i = 0; i < 10; i++) send_bit(~i[0]);
        hop_pulse();
        chk("R4 staging untouched", {12'd0, active_word}, {12'd0, act_m});

        // R8 then R6: load staging, commit with aux selected, then hop
        shift_word(32'h000C_3A5E, 20, 1'b0);
        aux_sel = 1'b1;
        wait_clk(4);
        strobe_up();
        chk("R8 no commit", {12'd0, active_word}, {12'd0, act_m});
        hop_pulse();
        act_m = prim_m;
        chk("R6 hop commit", {12'd0, active_word}, 32'h000C_3A5E);

        // R6: hop while strobe low and mid-load
        shift_word(32'h0000_0ABC, 12, 1'b0);
        hop_pulse();
        act_m = prim_m;
        chk("R6 hop mid-load", {12'd0, active_word}, {12'd0, act_m});
        strobe_up();
        chk("R5 commit after hop", {12'd0, active_word}, {12'd0, prim_m});
        act_m = prim_m;

        // R9: overlong loads keep the last bits
        shift_word(32'h07AB_CDEF, 27, 1'b0);
        strobe_up();
        act_m = prim_m;
        chk("R9 staging last 20", {12'd0, active_word}, 32'h000B_CDEF);
        shift_word(32'h0000_05A7, 11, 1'b1);
        strobe_up();
        chk("R9 aux last 8", {24'd0, aux_word}, 32'h0000_00A7);
        chk("R8 active after aux", {12'd0, active_word}, 32'h000B_CDEF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule